// File: doc/BRIEF.md
# Periodic Micro-frame Poll Selector

This block decides, at the start of every 125 µs micro-frame, which periodic interrupt endpoints get a transaction slot. A free-running micro-frame counter arrives from outside. Its low three bits name the micro-frame inside the current 1 ms frame, and the bits above them form the frame number. Each of up to eight endpoint entries supplies four fields:

- an enable;
- an 8-bit start mask that picks micro-frames inside a frame;
- a poll-interval code that gives the frame period as a power of two;
- a phase that places the endpoint inside that period.

An endpoint is reachable in a frame when the frame number, taken modulo its interval, equals its phase. It is issued when it is reachable and its mask bit for the current micro-frame is set. Endpoints that share an interval can be spread over the schedule by giving them different phases or different mask bits.

A zero start mask is an illegal configuration. Such an entry never issues. Instead it latches a per-entry error bit, and that bit feeds a combined error flag.

Top module: `uframe_poll_sel`

## Requirements
- R1: `issue` is all zero except in the cycle directly after a cycle with `uf_start` high, and each such pulse lasts exactly one cycle unless `uf_start` is high again.
- R2: Bit k of an entry's 8-bit start mask allows issue only when `uf_count[2:0]` equals k.
- R3: The frame number is `uf_count[UF_W-1:3]`. An interval code c means 2^c frames, and an entry is reachable when frame mod 2^c equals phase mod 2^c. The phase bits at or above c are ignored.
- R4: Interval codes above `IVL_LOG2_MAX` (default 5, so 32 frames) are treated as `IVL_LOG2_MAX`.
- R5: An entry with its enable low never issues and never sets an error bit.
- R6: An enabled entry with a zero start mask never issues. At each `uf_start` it sets its bit in `mask_err_ep`, and that bit stays set until reset.
- R7: `mask_err` is high exactly when any bit of `mask_err_ep` is set. It is updated in the same cycle as the `issue` outputs, so an error and other entries' issue pulses can appear together.
- R8: After reset, `issue`, `mask_err_ep` and `mask_err` are all zero.
- R9: Entries are evaluated independently and in parallel. Any number of entries may issue in the same micro-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_start | input | 1 | High for one cycle at the start of a micro-frame |
| uf_count | input | UF_W | Free-running micro-frame counter: micro-frame in [2:0], frame number above |
| ep_en | input | N_EP | Per-entry enable |
| ep_smask | input | 8*N_EP | Per-entry start mask, entry i in bits [8i+7:8i] |
| ep_ilog | input | IV_W*N_EP | Per-entry interval code (log2 of frames), entry i in bits [IV_W*i +: IV_W] |
| ep_phase | input | IVL_LOG2_MAX*N_EP | Per-entry frame phase |
| issue | output | N_EP | One-cycle issue strobe per entry |
| mask_err_ep | output | N_EP | Sticky per-entry zero-mask error |
| mask_err | output | 1 | Any entry has a latched zero-mask error |

## Verification
Two things can land in the same cycle: a legal entry's issue pulse and the error latched by another entry whose mask is zero. The bench sets up that case with entry 0 reachable in the current slot and entry 2 enabled with a zero mask. It then checks in one sample that `issue` holds only bit 0, that `mask_err_ep` holds only bit 2, and that `mask_err` is high. After that it repairs entry 2's mask and confirms that the error bit stays set while legal issuing carries on.

// File: rtl/uframe_poll_sel.sv
module uframe_poll_sel #(
  parameter int N_EP         = 8,
  parameter int UF_W         = 14,
  parameter int IVL_LOG2_MAX = 5,
  parameter int IV_W         = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         uf_start,
  input  logic [UF_W-1:0]              uf_count,
  input  logic [N_EP-1:0]              ep_en,
  input  logic [8*N_EP-1:0]            ep_smask,
  input  logic [IV_W*N_EP-1:0]         ep_ilog,
  input  logic [IVL_LOG2_MAX*N_EP-1:0] ep_phase,
  output logic [N_EP-1:0]              issue,
  output logic [N_EP-1:0]              mask_err_ep,
  output logic                         mask_err
);
  localparam int PH_W = IVL_LOG2_MAX;

  logic [2:0]      uslot;
  logic [PH_W-1:0] frame_lo;
  logic [N_EP-1:0] hit, zmask;

  assign uslot    = uf_count[2:0];
  assign frame_lo = uf_count[3 +: PH_W];

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    logic [7:0]      sm;
    logic [IV_W-1:0] il, il_eff;
    logic [PH_W:0]   span;
    logic [PH_W-1:0] ph, wrap;
    logic            reach;

    assign sm     = ep_smask[8*i +: 8];
    assign il     = ep_ilog[IV_W*i +: IV_W];
    assign ph     = ep_phase[PH_W*i +: PH_W];
    assign il_eff = (int'(il) > IVL_LOG2_MAX) ? IV_W'(IVL_LOG2_MAX) : il;
    assign span   = (PH_W+1)'(1) << il_eff;
    assign wrap   = PH_W'(span - (PH_W+1)'(1));
    assign reach  = ((frame_lo ^ ph) & wrap) == '0;
    assign zmask  [i] = ep_en[i] && (sm == 8'h00);
    assign hit    [i] = ep_en[i] && !zmask[i] && sm[uslot] && reach;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue       <= '0;
      mask_err_ep <= '0;
    end else begin
      issue <= uf_start ? hit : '0;
      if (uf_start) mask_err_ep <= mask_err_ep | zmask;
    end
  end

  assign mask_err = |mask_err_ep;
endmodule

module uframe_poll_sel_chk #(
  parameter int N_EP = 8,
  parameter int UF_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                uf_start,
  input logic [UF_W-1:0]     uf_count,
  input logic [N_EP-1:0]     ep_en,
  input logic [8*N_EP-1:0]   ep_smask,
  input logic [N_EP-1:0]     issue,
  input logic [N_EP-1:0]     mask_err_ep
);
  logic            tick_q;
  logic [N_EP-1:0] en_q, zm_q, err_q, slot_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b0; en_q <= '0; zm_q <= '0; err_q <= '0; slot_ok_q <= '0;
    end else begin
      tick_q <= uf_start;
      en_q   <= ep_en;
      err_q  <= mask_err_ep;
      for (int i = 0; i < N_EP; i++) begin
        zm_q[i]      <= ep_smask[8*i +: 8] == 8'h00;
        slot_ok_q[i] <= ep_smask[8*i + int'(uf_count[2:0])];
      end
    end
  end

  a_r1_issue_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_q |-> issue == '0);
  a_r2_slot_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (issue & ~slot_ok_q) == '0);
  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (issue & ~en_q) == '0);
  a_r6_zero_never_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (issue & zm_q) == '0);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & ~mask_err_ep) == '0);
  a_r6_err_latched: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (zm_q & en_q & ~mask_err_ep) == '0);
endmodule

bind uframe_poll_sel uframe_poll_sel_chk #(.N_EP(N_EP), .UF_W(UF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uf_start(uf_start), .uf_count(uf_count),
  .ep_en(ep_en), .ep_smask(ep_smask), .issue(issue), .mask_err_ep(mask_err_ep)
);

// File: tb/tb_uframe_poll_sel.sv
module tb_uframe_poll_sel;
  localparam int CLK_P = 10;
  localparam int N_EP = 8, UF_W = 14, PH_W = 5, IV_W = 3;
  localparam int NV = 17;
  // {uf_count[13:0], mask[7:0], ilog[2:0], phase[4:0], expected}
  localparam logic [30:0] VEC [NV] = '{
    {14'd0,   8'h01, 3'd1, 5'd0, 1'b1},  // R2/R3 frame 0 uf 0
    {14'd1,   8'h01, 3'd1, 5'd0, 1'b0},  // R2 wrong slot
    {14'd8,   8'h01, 3'd1, 5'd0, 1'b0},  // R3 odd frame
    {14'd16,  8'h01, 3'd1, 5'd0, 1'b1},  // R3 frame 2
    {14'd17,  8'h02, 3'd1, 5'd0, 1'b1},  // R2 slot 1
    {14'd25,  8'h02, 3'd1, 5'd1, 1'b1},  // R3 odd phase
    {14'd33,  8'h02, 3'd1, 5'd1, 1'b0},  // R3 frame 4 phase 1
    {14'd47,  8'h80, 3'd0, 5'd9, 1'b1},  // R3 interval 1 ignores phase
    {14'd99,  8'h08, 3'd2, 5'd0, 1'b1},  // R3 frame 12 mod 4
    {14'd107, 8'h08, 3'd2, 5'd1, 1'b1},  // R3 frame 13 mod 4
    {14'd107, 8'h08, 3'd2, 5'd5, 1'b1},  // R3 phase high bits ignored
    {14'd107, 8'h08, 3'd2, 5'd2, 1'b0},  // R3 phase miss
    {14'd301, 8'h20, 3'd5, 5'd5, 1'b1},  // R3 frame 37 mod 32
    {14'd557, 8'h20, 3'd7, 5'd5, 1'b1},  // R4 code 7 acts as 32
    {14'd557, 8'hDF, 3'd5, 5'd5, 1'b0},  // R2 slot bit clear
    {14'd52,  8'hFF, 3'd3, 5'd6, 1'b1},  // R3 frame 6 mod 8
    {14'd60,  8'hFF, 3'd3, 5'd6, 1'b0}   // R3 frame 7 mod 8
  };

  logic clk = 1'b0, rst_n = 1'b0, uf_start = 1'b0;
  logic [UF_W-1:0] uf_count = '0;
  logic [N_EP-1:0] ep_en = '0;
  logic [8*N_EP-1:0] ep_smask = '0;
  logic [IV_W*N_EP-1:0] ep_ilog = '0;
  logic [PH_W*N_EP-1:0] ep_phase = '0;
  logic [N_EP-1:0] issue, mask_err_ep;
  logic mask_err;
  int checks = 0, errors = 0;
  bit done = 0;

  uframe_poll_sel dut (
    .clk(clk), .rst_n(rst_n), .uf_start(uf_start), .uf_count(uf_count),
    .ep_en(ep_en), .ep_smask(ep_smask), .ep_ilog(ep_ilog), .ep_phase(ep_phase),
    .issue(issue), .mask_err_ep(mask_err_ep), .mask_err(mask_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [UF_W-1:0] uc);
    @(negedge clk); uf_count = uc; uf_start = 1'b1;
    @(negedge clk); uf_start = 1'b0;
  endtask

  task automatic set_ep(input int i, input logic [7:0] m, input logic [2:0] il, input logic [4:0] ph);
    ep_smask[8*i +: 8] = m; ep_ilog[IV_W*i +: IV_W] = il; ep_phase[PH_W*i +: PH_W] = ph;
  endtask

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 issue", 32'(issue), 0);
    chk("R8 err_ep", 32'(mask_err_ep), 0);
    chk("R8 mask_err", 32'(mask_err), 0);
    rst_n = 1'b1;

    ep_en = 8'h01;
    for (int v = 0; v < NV; v++) begin
      set_ep(0, VEC[v][16:9], VEC[v][8:6], VEC[v][5:1]);
      tick(VEC[v][30:17]);
      chk($sformatf("R2/R3/R4 vec %0d", v), 32'(issue), 32'(VEC[v][0]));
    end

    // R1: pulse lasts one cycle; no issue without uf_start
    set_ep(0, 8'h01, 3'd0, 5'd0);
    tick(14'd0);
    chk("R1 pulse", 32'(issue), 1);
    @(negedge clk);
    chk("R1 pulse end", 32'(issue), 0);
    uf_count = 14'd0;
    repeat (2) @(negedge clk);
    chk("R1 no start", 32'(issue), 0);

    // R5: disabled entries, matching slot and zero mask
    ep_en = 8'h00;
    set_ep(1, 8'h00, 3'd0, 5'd0);
    tick(14'd0);
    chk("R5 no issue", 32'(issue), 0);
    chk("R5 no err", 32'(mask_err_ep), 0);

    // R9: all entries issue together
    ep_en = 8'hFF;
    for (int i = 0; i < N_EP; i++) set_ep(i, 8'hFF, 3'd0, 5'd0);
    tick(14'd3);
    chk("R9 all issue", 32'(issue), 32'hFF);

    // R6/R7 concurrent: entry 0 issues while entry 2 has zero mask
    ep_en = 8'h05;
    set_ep(2, 8'h00, 3'd0, 5'd0);
    tick(14'd4);
    chk("R6 issue only ep0", 32'(issue), 1);
    chk("R6 err ep2", 32'(mask_err_ep), 4);
    chk("R7 flag", 32'(mask_err), 1);
    set_ep(2, 8'hFF, 3'd0, 5'd0);
    tick(14'd5);
    chk("R6 sticky", 32'(mask_err_ep), 4);
    chk("R9 both issue after fix", 32'(issue), 5);
    chk("R7 flag held", 32'(mask_err), 1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R8 err cleared", 32'(mask_err_ep), 0);
    chk("R7 flag cleared", 32'(mask_err), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule